// File: doc/BRIEF.md
# Multi-Mode ADC Conversion Sequencer

This controller decides when an analog-to-digital converter core samples and which input channel it samples. Software sets a 2-bit start-mode field and writes a channel-enable mask into a conversion register. Once a start is accepted, the block pulses `coreStart` with a channel number on `coreChan`. It waits for the core's `coreDone` and then moves on. Acquisition and conversion pacing come from the core and this sequencer. The width of the external strobe has no effect on them.

A start can come from a conversion-register write or from a falling edge on the active-low asynchronous strobe `startStbN`. The mode field decides which of these counts and how far each start walks through the enabled channels. One mode runs the whole enabled set on a register write. One runs the whole set on every strobe edge. One advances a single channel per strobe edge and remembers its place between edges. The remaining code is reserved and keeps the block idle. A busy flag covers each accepted sequence, a one-cycle pulse marks its end, and a per-channel valid flag shows which channels hold a fresh conversion.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset `busy`, `seqDone` and `coreStart` are low, `chanValid` is all zero, the mode field is 00 and the enable mask is zero.
- R2: In mode 00, a conversion-register write with a nonzero mask is accepted at the clock edge that samples `convWrEn`. `busy` and `coreStart` are high in the cycle after that edge. The enabled channels are then converted from lowest index to highest, and disabled channels are skipped.
- R3: In mode 01, each falling edge of `startStbN` starts the full ascending sequence over the stored mask. With `startStbN` first seen low at clock edge k, `coreStart` is high after edge k+2. In this mode a conversion-register write starts nothing.
- R4: Mode 10 is reserved: register writes and strobe edges start nothing and `busy` stays low.
- R5: In mode 11, each strobe falling edge converts exactly one channel. This is the lowest enabled channel at or above the stored position. The position then moves one past the converted channel, and the search wraps from the highest enabled channel back to the lowest.
- R6: A start request that arrives while `busy` is high is ignored.
- R7: A conversion-register write with an all-zero mask starts nothing. A strobe edge while the stored mask is zero starts nothing.
- R8: Any conversion-register write, or a write that changes the mode field, resets the mode-11 position to channel 0.
- R9: `coreStart` is a one-cycle pulse per channel. `coreChan` holds steady while the core is converting. The next channel is issued only after `coreDone`.
- R10: `seqDone` is a one-cycle pulse in the cycle after the last channel's `coreDone`. `busy` stays high from the accepted start until that pulse and is low during it.
- R11: `chanValid[c]` clears when a conversion of channel c is accepted and sets when its `coreDone` arrives. The bits of channels outside the sequence keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Writes `cfgMode` into the mode field |
| cfgMode | input | 2 | Start mode: 00 register write, 01 full set per strobe, 10 reserved, 11 one channel per strobe |
| convWrEn | input | 1 | Conversion-register write strobe |
| convMask | input | CHANS | Channel-enable mask, bit c enables channel c |
| startStbN | input | 1 | Asynchronous active-low conversion-start strobe |
| coreDone | input | 1 | Converter core finished the current channel |
| coreStart | output | 1 | One-cycle start pulse to the core |
| coreChan | output | CW | Channel for the core to convert |
| busy | output | 1 | A sequence is in progress |
| seqDone | output | 1 | One-cycle end-of-sequence pulse |
| chanValid | output | CHANS | Per-channel fresh-result flags |

## Verification
Results arrive at fixed delays. After a register write, `coreStart` and `busy` show up one edge later. After the strobe is first sampled low, `coreStart` shows up three edges later. After the last `coreDone`, `seqDone` shows up one edge later. A core model answers each `coreStart` with `coreDone` three cycles later. The bench drives inputs on falling clock edges and samples on the following falling edge after the number of rising edges stated above, so each check lands in the exact cycle its result is due. A scoreboard queue holds the expected channel order, and the monitor compares each `coreStart` against its head. Because of this, ignored starts (reserved mode, zero mask, strobes during busy) show up as unexpected pulses.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadFirst;  // latch sequence mask and first channel
    logic advance;    // step to next enabled channel
    logic markValid;  // current channel finished
  } seqCmd_t;

  localparam logic [1:0] MODE_REG_ALL  = 2'b00;
  localparam logic [1:0] MODE_STB_ALL  = 2'b01;
  localparam logic [1:0] MODE_RESERVED = 2'b10;
  localparam logic [1:0] MODE_STB_ONE  = 2'b11;

endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CHANS = 4,
  parameter int CW    = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgMode,
  input  logic             convWrEn,
  input  logic [CHANS-1:0] convMask,
  input  logic             startStbN,
  input  seqCmd_t          cmd,
  output logic             trigReq,
  output logic             hasNext,
  output logic             singleSeq,
  output logic [CW-1:0]    curChan,
  output logic [CHANS-1:0] chanValid
);

  localparam int SYNC_STAGES = 3;

  logic [1:0]             modeQ;
  logic [CHANS-1:0]       maskQ;
  logic [CHANS-1:0]       seqMaskQ;
  logic [CW-1:0]          ptrQ;
  logic [CW-1:0]          curQ;
  logic                   singleQ;
  logic [CHANS-1:0]       validQ;
  logic [SYNC_STAGES-1:0] syncQ;

  logic             stbFall;
  logic             oneMode;
  logic [CHANS-1:0] srcMask;
  logic [CHANS-1:0] clrMask;
  logic [CW:0]      firstPick;
  logic [CW:0]      nextPick;
  logic             ptrReset;

  // Lowest enabled channel at or above 'from'; optional wrap to lowest overall
  function automatic logic [CW:0] pickChan(input logic [CHANS-1:0] m,
                                           input int from, input logic wrap);
    logic [CW:0] r;
    r = '0;
    for (int i = CHANS - 1; i >= 0; i--)
      if (m[i] && i >= from) r = {1'b1, CW'(i)};
    if (!r[CW] && wrap)
      for (int i = CHANS - 1; i >= 0; i--)
        if (m[i]) r = {1'b1, CW'(i)};
    return r;
  endfunction

  assign stbFall  = syncQ[2] & ~syncQ[1];
  assign oneMode  = (modeQ == MODE_STB_ONE);
  assign srcMask  = (modeQ == MODE_REG_ALL) ? convMask : maskQ;
  assign ptrReset = convWrEn || (cfgWrEn && (cfgMode != modeQ));

  always_comb begin
    unique case (modeQ)
      MODE_REG_ALL: trigReq = convWrEn && (|convMask);
      MODE_STB_ALL,
      MODE_STB_ONE: trigReq = stbFall && (|maskQ);
      default:      trigReq = 1'b0;
    endcase
  end

  assign firstPick = pickChan(srcMask, oneMode ? int'(ptrQ) : 0, oneMode);
  assign nextPick  = pickChan(seqMaskQ, int'(curQ) + 1, 1'b0);
  assign clrMask   = oneMode ? ({{(CHANS-1){1'b0}}, 1'b1} << firstPick[CW-1:0])
                             : srcMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      modeQ    <= MODE_REG_ALL;
      maskQ    <= '0;
      seqMaskQ <= '0;
      ptrQ     <= '0;
      curQ     <= '0;
      singleQ  <= 1'b0;
      validQ   <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], startStbN};
      if (cfgWrEn)  modeQ <= cfgMode;
      if (convWrEn) maskQ <= convMask;

      if (ptrReset)
        ptrQ <= '0;
      else if (cmd.markValid && singleQ)
        ptrQ <= (curQ == CW'(CHANS - 1)) ? '0 : curQ + 1'b1;

      if (cmd.loadFirst) begin
        seqMaskQ <= srcMask;
        curQ     <= firstPick[CW-1:0];
        singleQ  <= oneMode;
        validQ   <= validQ & ~clrMask;
      end else begin
        if (cmd.advance)   curQ <= nextPick[CW-1:0];
        if (cmd.markValid) validQ[curQ] <= 1'b1;
      end
    end
  end

  assign hasNext   = nextPick[CW];
  assign singleSeq = singleQ;
  assign curChan   = curQ;
  assign chanValid = validQ;

  p_reserved_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_RESERVED) |-> !trigReq);

  p_ptr_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    convWrEn |=> (ptrQ == '0));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    trigReq,
  input  logic    hasNext,
  input  logic    singleSeq,
  input  logic    coreDone,
  output seqCmd_t cmd,
  output logic    coreStart,
  output logic    busy,
  output logic    seqDone
);

  seqState_t stateQ, stateD;
  logic      doneQ;
  logic      lastDone;

  always_comb begin
    cmd.loadFirst = (stateQ == ST_IDLE) && trigReq;
    cmd.markValid = (stateQ == ST_WAIT) && coreDone;
    cmd.advance   = cmd.markValid && !singleSeq && hasNext;
    lastDone      = cmd.markValid && !cmd.advance;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (trigReq) stateD = ST_ISSUE;
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT:  if (cmd.advance) stateD = ST_ISSUE;
                else if (lastDone) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= lastDone;
    end
  end

  assign coreStart = (stateQ == ST_ISSUE);
  assign busy      = (stateQ != ST_IDLE);
  assign seqDone   = doneQ;

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> !coreStart);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !busy);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CHANS = 4,
  parameter int CW    = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgMode,
  input  logic             convWrEn,
  input  logic [CHANS-1:0] convMask,
  input  logic             startStbN,
  input  logic             coreDone,
  output logic             coreStart,
  output logic [CW-1:0]    coreChan,
  output logic             busy,
  output logic             seqDone,
  output logic [CHANS-1:0] chanValid
);

  seqCmd_t cmd;
  logic    trigReq;
  logic    hasNext;
  logic    singleSeq;

  adc_seq_datapath #(.CHANS(CHANS), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .convWrEn(convWrEn), .convMask(convMask),
    .startStbN(startStbN), .cmd(cmd),
    .trigReq(trigReq), .hasNext(hasNext), .singleSeq(singleSeq),
    .curChan(coreChan), .chanValid(chanValid)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rstN(rstN),
    .trigReq(trigReq), .hasNext(hasNext), .singleSeq(singleSeq),
    .coreDone(coreDone), .cmd(cmd),
    .coreStart(coreStart), .busy(busy), .seqDone(seqDone)
  );

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigReq) |=> busy);

  p_chan_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !coreStart && !coreDone) |=> $stable(coreChan));

endmodule

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;
  localparam int CHANS = 4;
  localparam int CW    = 2;
  localparam int LAT   = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [1:0]       cfgMode = 2'b00;
  logic             convWrEn = 1'b0;
  logic [CHANS-1:0] convMask = '0;
  logic             startStbN = 1'b1;
  logic             coreDone;
  logic             coreStart;
  logic [CW-1:0]    coreChan;
  logic             busy;
  logic             seqDone;
  logic [CHANS-1:0] chanValid;

  int errors = 0;
  int checks = 0;
  int expQ[$];
  int pend;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_conv_sequencer #(.CHANS(CHANS), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .convWrEn(convWrEn), .convMask(convMask), .startStbN(startStbN),
    .coreDone(coreDone), .coreStart(coreStart), .coreChan(coreChan),
    .busy(busy), .seqDone(seqDone), .chanValid(chanValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Core model: answers each coreStart with a coreDone LAT cycles later
  always @(negedge clk) begin
    if (!rstN) begin
      coreDone = 1'b0;
      pend = 0;
    end else begin
      coreDone = (pend == 1);
      if (pend > 0) pend--;
      if (coreStart) pend = LAT;
    end
  end

  // Monitor / scoreboard for issued channels (R2 R3 R5 R6 R9)
  always @(negedge clk) begin
    if (rstN && coreStart) begin
      if (expQ.size() == 0)
        check(0, "R6 unexpected coreStart", int'(coreChan), -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(int'(coreChan) == e, "R2/R5 channel order", int'(coreChan), e);
      end
    end
  end

  task automatic cfgWrite(input logic [1:0] m);
    @(negedge clk); cfgWrEn = 1'b1; cfgMode = m;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic convWrite(input logic [CHANS-1:0] m);
    @(negedge clk); convWrEn = 1'b1; convMask = m;
    @(posedge clk);
    @(negedge clk); convWrEn = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); startStbN = 1'b0;
    repeat (2) @(negedge clk);
    startStbN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitDone(input string req);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (seqDone) begin
        check(busy == 1'b0, req, int'(busy), 0);
        return;
      end
    end
    check(0, {req, " seqDone timeout"}, 0, 1);
  endtask

  task automatic quiet(input int n, input string req);
    repeat (n) @(negedge clk);
    check(busy == 1'b0, req, int'(busy), 0);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && seqDone == 0 && coreStart == 0, "R1 reset outputs", {busy, seqDone, coreStart}, 0);
    check(chanValid == '0, "R1 reset chanValid", chanValid, 0);

    // R2 mode 00: mask 1011 -> channels 0,1,3
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(3);
    convWrite(4'b1011);
    check(busy == 1 && coreStart == 1, "R2 accept latency", {busy, coreStart}, 3);
    waitDone("R10 busy low at seqDone");
    check(expQ.size() == 0, "R2 all channels issued", expQ.size(), 0);
    check(chanValid == 4'b1011, "R11 valid after mode 00", chanValid, 4'b1011);

    // R7 zero mask write starts nothing
    convWrite(4'b0000);
    quiet(10, "R7 zero mask idle");
    check(chanValid == 4'b1011, "R7 valid unchanged", chanValid, 4'b1011);

    // R3 mode 01: register write does not start; strobe runs full set
    cfgWrite(2'b01);
    convWrite(4'b0110);
    quiet(10, "R3 write ignored in mode 01");
    expQ.push_back(1); expQ.push_back(2);
    strobe();
    strobe();  // R6: lands while busy, must be ignored
    waitDone("R10 busy low at seqDone mode 01");
    quiet(10, "R6 strobe while busy ignored");
    check(chanValid == 4'b1111, "R11 valid after mode 01", chanValid, 4'b1111);
    expQ.push_back(1); expQ.push_back(2);
    strobe();
    waitDone("R3 second strobe sequence");

    // R4 reserved mode ignores everything
    cfgWrite(2'b10);
    strobe();
    convWrite(4'b1111);
    strobe();
    quiet(15, "R4 reserved mode idle");

    // R5 mode 11 with mask 1101: 0,2,3,0 with wrap
    cfgWrite(2'b11);
    convWrite(4'b1101);
    expQ.push_back(0);
    @(negedge clk); startStbN = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(busy == 0, "R3 strobe latency early", busy, 0);
    @(posedge clk);
    @(negedge clk);
    check(coreStart == 1, "R3 strobe latency k+2", coreStart, 1);
    check(chanValid == 4'b1110, "R11 valid cleared at accept", chanValid, 4'b1110);
    startStbN = 1'b1;
    waitDone("R5 single channel done");
    check(chanValid == 4'b1111, "R11 valid set on done", chanValid, 4'b1111);
    expQ.push_back(2); strobe(); waitDone("R5 step to 2");
    expQ.push_back(3); strobe(); waitDone("R5 step to 3");
    expQ.push_back(0); strobe(); waitDone("R5 wrap to 0");
    check(expQ.size() == 0, "R5 order consumed", expQ.size(), 0);

    // R8 mask write resets position
    convWrite(4'b1100);
    expQ.push_back(2); strobe(); waitDone("R8 mask write reset");
    // R8 mode change resets position (position now 3)
    cfgWrite(2'b01);
    cfgWrite(2'b11);
    expQ.push_back(2); strobe(); waitDone("R8 mode change reset");

    // R7 zero mask in mode 11: strobe starts nothing
    convWrite(4'b0000);
    strobe();
    quiet(10, "R7 zero mask strobe idle");
    convWrite(4'b1101);
    expQ.push_back(0); strobe(); waitDone("R8 position at lowest after zero mask");
    check(expQ.size() == 0, "R5 scoreboard empty", expQ.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule